// File: doc/BRIEF.md
# Memory Protection Configuration Register Bank

This block stores the settings of a small array of physical memory protection entries: one 8-bit configuration byte and one address register per entry, plus a three-bit security-configuration register. Software reaches all of them through a simple register port. The port carries a register kind, a register index, a write strobe and write data. Read data comes back combinationally. Each configuration register packs one byte per entry, so a single access covers XLEN/8 neighbouring entries.

Whether a write takes effect depends on several things: the lock bit of the entry being written, the lock and match mode of the following entry (for address registers), and the enhanced-security mode bits. The rule-lock bypass bit can relax these rules. The lockdown and whitelist bits stick once set. All stored state is driven out on flat buses for the range decoder and the access checker. A one-cycle pulse marks every real change of a configuration byte or an address register, so that downstream caches can be invalidated.

Top module: `pmp_csr_bank`

## Requirements
- R1: Register kind 2'b00 selects a configuration register. Byte i (data bits [8i+7:8i]) of configuration register n belongs to entry n*(XLEN/8)+i, and a read packs the bytes the same way. Within a byte, bit 0 is read, bit 1 is write, bit 2 is execute, bits [4:3] are the match mode (2'b01 = top-of-range) and bit 7 is lock.
- R2: When `enh_en` is low, a write to a configuration byte whose stored lock bit is set is dropped. The other bytes of the same register are still written.
- R3: When `enh_en` is high and the bypass bit is set, configuration byte writes are accepted even to locked entries.
- R4: When `enh_en` is high and both bypass and lockdown are clear, a configuration byte write is accepted only if the entry is unlocked.
- R5: When `enh_en` is high and lockdown is set, a configuration byte write is also accepted if the new byte has lock=1 and execute=0, or if it has lock=0 and its bits [2:0] are not 3'b110. Any other new byte is dropped unless bypass is set.
- R6: An address write (kind 2'b01, index = entry) is dropped if the entry is locked, or if the next entry is locked with match mode 2'b01. In every other case it is accepted.
- R7: The security register (kind 2'b10) holds lockdown in bit 0, whitelist in bit 1 and bypass in bit 2. Once set, lockdown and whitelist cannot be cleared by any write.
- R8: Bypass cannot change from 0 to 1 while any entry's lock bit is set.
- R9: Writes to a configuration index at or beyond NUM_ENTRIES/(XLEN/8), to an address index at or beyond NUM_ENTRIES, or with kind 2'b11 change nothing, and reads of those locations return zero.
- R10: Reset clears every configuration byte, address register and security bit, as well as the change pulse.
- R11: `cfg_changed` is high for exactly the cycle after a write that altered a stored configuration byte or address value. It stays low after writes that leave values unchanged and after security-register writes.
- R12: Entry e's configuration byte appears on `cfg_flat[8e+7:8e]` and its address on `addr_flat[XLEN*e+XLEN-1:XLEN*e]`. The three security bits have their own outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enh_en | input | 1 | Enables the enhanced-security write rules |
| csr_we | input | 1 | Write strobe |
| csr_kind | input | 2 | 00 config, 01 address, 10 security, 11 unused |
| csr_idx | input | $clog2(NUM_ENTRIES)+1 | Register index within the kind |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for kind/index, combinational |
| cfg_flat | output | 8*NUM_ENTRIES | All configuration bytes |
| addr_flat | output | XLEN*NUM_ENTRIES | All address registers |
| sec_lockdown | output | 1 | Lockdown bit |
| sec_whitelist | output | 1 | Whitelist-policy bit |
| sec_bypass | output | 1 | Rule-lock bypass bit |
| cfg_changed | output | 1 | One-cycle pulse after a stored value changed |

## Verification
The write-acceptance rules are tried with mixed packed writes in which locked and unlocked bytes share one register. This separates per-byte gating from whole-register gating. Lockdown is tested with four new-byte patterns (lock with execute, lock without execute, unlocked write-plus-execute, unlocked full permission), each of which takes a different branch of the rule. Address writes are aimed at entries whose successor is locked in top-of-range mode, locked in another mode, and unlocked in top-of-range mode, which isolates the successor test from the entry's own lock. Bypass is requested both with and without locked entries, and sticky bits are tested by writing zero after setting them.

// File: rtl/pmp_csr_pkg.sv
package pmp_csr_pkg;

  typedef enum logic [1:0] {
    KIND_CFG  = 2'b00,
    KIND_ADDR = 2'b01,
    KIND_SEC  = 2'b10,
    KIND_NONE = 2'b11
  } csr_kind_e;

  localparam int BIT_EX   = 2;
  localparam int BIT_LOCK = 7;
  localparam logic [1:0] MODE_TOR = 2'b01;

  // Decide whether a new configuration byte may replace the stored one.
  function automatic logic cfg_write_ok(input logic enh, input logic bypass,
                                        input logic lockdown,
                                        input logic [7:0] cur,
                                        input logic [7:0] nxt);
    logic ok;
    if (!enh) begin
      ok = !cur[BIT_LOCK];
    end else begin
      ok = bypass | (!lockdown & !cur[BIT_LOCK]);
      if (lockdown) begin
        ok = ok | (nxt[BIT_LOCK] & !nxt[BIT_EX])
                | (!nxt[BIT_LOCK] & (nxt[2:0] != 3'b110));
      end
    end
    return ok;
  endfunction

  // Address register write gate: own lock, or locked top-of-range successor.
  function automatic logic addr_write_ok(input logic [7:0] own_cfg,
                                         input logic [7:0] next_cfg);
    return !own_cfg[BIT_LOCK] &&
           !(next_cfg[BIT_LOCK] && (next_cfg[4:3] == MODE_TOR));
  endfunction

endpackage

// File: rtl/pmp_entry_slot.sv
module pmp_entry_slot
  import pmp_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enh_en,
  input  logic            bypass,
  input  logic            lockdown,
  input  logic            cfg_we,
  input  logic [7:0]      cfg_wbyte,
  input  logic            addr_we,
  input  logic [XLEN-1:0] addr_wdata,
  input  logic [7:0]      next_cfg,
  output logic [7:0]      cfg_q,
  output logic [XLEN-1:0] addr_q,
  output logic            cfg_commit,
  output logic            addr_commit,
  output logic            changed
);

  assign cfg_commit  = cfg_we  && cfg_write_ok(enh_en, bypass, lockdown, cfg_q, cfg_wbyte);
  assign addr_commit = addr_we && addr_write_ok(cfg_q, next_cfg);
  assign changed     = (cfg_commit  && (cfg_wbyte  != cfg_q)) ||
                       (addr_commit && (addr_wdata != addr_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else begin
      if (cfg_commit)  cfg_q  <= cfg_wbyte;
      if (addr_commit) addr_q <= addr_wdata;
    end
  end

endmodule

// File: rtl/pmp_sec_reg.sv
module pmp_sec_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [2:0] wdata,
  input  logic       any_locked,
  output logic       lockdown,
  output logic       whitelist,
  output logic       bypass
);

  logic bypass_next;

  // Bypass may only rise while no entry is locked; it may always fall.
  assign bypass_next = wdata[2] & (bypass | !any_locked);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lockdown  <= 1'b0;
      whitelist <= 1'b0;
      bypass    <= 1'b0;
    end else if (we) begin
      lockdown  <= lockdown  | wdata[0];
      whitelist <= whitelist | wdata[1];
      bypass    <= bypass_next;
    end
  end

endmodule

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
  import pmp_csr_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enh_en,
  input  logic                        csr_we,
  input  logic [1:0]                  csr_kind,
  input  logic [IDX_W-1:0]            csr_idx,
  input  logic [XLEN-1:0]             csr_wdata,
  output logic [XLEN-1:0]             csr_rdata,
  output logic [8*NUM_ENTRIES-1:0]    cfg_flat,
  output logic [XLEN*NUM_ENTRIES-1:0] addr_flat,
  output logic                        sec_lockdown,
  output logic                        sec_whitelist,
  output logic                        sec_bypass,
  output logic                        cfg_changed
);

  localparam int BPC      = XLEN / 8;
  localparam int NUM_CFGS = (NUM_ENTRIES + BPC - 1) / BPC;

  logic [7:0]      cfg_arr  [NUM_ENTRIES];
  logic [XLEN-1:0] addr_arr [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] lock_vec;
  logic [NUM_ENTRIES-1:0] slot_changed;
  logic [NUM_ENTRIES-1:0] cfg_commit;
  logic [NUM_ENTRIES-1:0] addr_commit;
  logic any_locked;
  logic sec_we;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
    localparam int CSR_N  = e / BPC;
    localparam int BYTE_I = e % BPC;
    logic       cfg_sel;
    logic       addr_sel;
    logic [7:0] nxt_cfg;

    assign cfg_sel  = csr_we && (csr_kind == KIND_CFG)  && (csr_idx == IDX_W'(CSR_N));
    assign addr_sel = csr_we && (csr_kind == KIND_ADDR) && (csr_idx == IDX_W'(e));

    if (e + 1 < NUM_ENTRIES) begin : g_next
      assign nxt_cfg = cfg_arr[e+1];
    end else begin : g_last
      assign nxt_cfg = 8'h00;
    end

    pmp_entry_slot #(.XLEN(XLEN)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .enh_en     (enh_en),
      .bypass     (sec_bypass),
      .lockdown   (sec_lockdown),
      .cfg_we     (cfg_sel),
      .cfg_wbyte  (csr_wdata[8*BYTE_I +: 8]),
      .addr_we    (addr_sel),
      .addr_wdata (csr_wdata),
      .next_cfg   (nxt_cfg),
      .cfg_q      (cfg_arr[e]),
      .addr_q     (addr_arr[e]),
      .cfg_commit (cfg_commit[e]),
      .addr_commit(addr_commit[e]),
      .changed    (slot_changed[e])
    );

    assign lock_vec[e]                  = cfg_arr[e][BIT_LOCK];
    assign cfg_flat[8*e +: 8]           = cfg_arr[e];
    assign addr_flat[XLEN*e +: XLEN]    = addr_arr[e];
  end

  assign any_locked = |lock_vec;
  assign sec_we     = csr_we && (csr_kind == KIND_SEC);

  pmp_sec_reg u_sec (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (sec_we),
    .wdata     (csr_wdata[2:0]),
    .any_locked(any_locked),
    .lockdown  (sec_lockdown),
    .whitelist (sec_whitelist),
    .bypass    (sec_bypass)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_changed <= 1'b0;
    else        cfg_changed <= |slot_changed;
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_kind)
      KIND_CFG: begin
        if (int'(csr_idx) < NUM_CFGS) begin
          for (int e = 0; e < NUM_ENTRIES; e++) begin
            if ((e / BPC) == int'(csr_idx)) csr_rdata[8*(e%BPC) +: 8] = cfg_arr[e];
          end
        end
      end
      KIND_ADDR: begin
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          if (e == int'(csr_idx)) csr_rdata = addr_arr[e];
        end
      end
      KIND_SEC: csr_rdata[2:0] = {sec_bypass, sec_whitelist, sec_lockdown};
      default:  csr_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pmp_csr_bank_chk.sv
module pmp_csr_bank_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES) + 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        enh_en,
  input logic                        csr_we,
  input logic [1:0]                  csr_kind,
  input logic [IDX_W-1:0]            csr_idx,
  input logic [XLEN-1:0]             csr_rdata,
  input logic [8*NUM_ENTRIES-1:0]    cfg_flat,
  input logic [XLEN*NUM_ENTRIES-1:0] addr_flat,
  input logic                        sec_lockdown,
  input logic                        sec_whitelist,
  input logic                        sec_bypass,
  input logic                        cfg_changed,
  input logic                        any_locked
);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    AST_BASE_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!enh_en && cfg_flat[8*e+7]) |=> $stable(cfg_flat[8*e +: 8])); // R2

    AST_ADDR_OWN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_flat[8*e+7] |=> $stable(addr_flat[XLEN*e +: XLEN])); // R6

    if (e + 1 < NUM_ENTRIES) begin : g_nx
      AST_ADDR_NEXT_TOR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flat[8*(e+1)+7] && cfg_flat[8*(e+1)+3 +: 2] == 2'b01)
        |=> $stable(addr_flat[XLEN*e +: XLEN])); // R6
    end
  end

  AST_LOCKDOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sec_lockdown |=> sec_lockdown); // R7

  AST_WHITELIST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sec_whitelist |=> sec_whitelist); // R7

  AST_BYPASS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_bypass) |-> !$past(any_locked)); // R8

  AST_NONE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_kind == 2'b11) |-> (csr_rdata == '0)); // R9

  AST_ADDR_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_kind == 2'b01 && int'(csr_idx) >= NUM_ENTRIES) |-> (csr_rdata == '0)); // R9

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_changed |-> $past(csr_we && (csr_kind == 2'b00 || csr_kind == 2'b01))); // R11

endmodule

bind pmp_csr_bank pmp_csr_bank_chk #(.NUM_ENTRIES(NUM_ENTRIES), .XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enh_en       (enh_en),
  .csr_we       (csr_we),
  .csr_kind     (csr_kind),
  .csr_idx      (csr_idx),
  .csr_rdata    (csr_rdata),
  .cfg_flat     (cfg_flat),
  .addr_flat    (addr_flat),
  .sec_lockdown (sec_lockdown),
  .sec_whitelist(sec_whitelist),
  .sec_bypass   (sec_bypass),
  .cfg_changed  (cfg_changed),
  .any_locked   (any_locked)
);

// File: tb/pmp_csr_bank_bench.sv
module pmp_csr_bank_bench;

  localparam int N     = 16;
  localparam int XL    = 32;
  localparam int IDX_W = $clog2(N) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enh_en = 1'b0;
  logic csr_we = 1'b0;
  logic [1:0] csr_kind = 2'b00;
  logic [IDX_W-1:0] csr_idx = '0;
  logic [XL-1:0] csr_wdata = '0;
  logic [XL-1:0] csr_rdata;
  logic [8*N-1:0] cfg_flat;
  logic [XL*N-1:0] addr_flat;
  logic sec_lockdown, sec_whitelist, sec_bypass, cfg_changed;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pmp_csr_bank #(.NUM_ENTRIES(N), .XLEN(XL)) u_pmp_csr_bank (
    .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .csr_we(csr_we),
    .csr_kind(csr_kind), .csr_idx(csr_idx), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .cfg_flat(cfg_flat), .addr_flat(addr_flat),
    .sec_lockdown(sec_lockdown), .sec_whitelist(sec_whitelist),
    .sec_bypass(sec_bypass), .cfg_changed(cfg_changed)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    csr_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] k, input int i, input logic [XL-1:0] d);
    @(negedge clk);
    csr_kind  = k;
    csr_idx   = IDX_W'(i);
    csr_wdata = d;
    csr_we    = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] k, input int i, output logic [XL-1:0] d);
    csr_kind = k;
    csr_idx  = IDX_W'(i);
    #1 d = csr_rdata;
  endtask

  task automatic t_reset();
    logic [XL-1:0] d;
    rd(2'b00, 0, d);  check("R10 cfg0 after reset", d, 0);
    check("R10 cfg_flat after reset", 64'(|cfg_flat), 0);
    check("R10 addr_flat after reset", 64'(|addr_flat), 0);
    rd(2'b10, 0, d);  check("R10 security after reset", d, 0);
    check("R10 pulse after reset", cfg_changed, 0);
  endtask

  task automatic t_packing();
    logic [XL-1:0] d;
    wr(2'b00, 1, 32'h0F0B_0903);
    check("R11 pulse on change", cfg_changed, 1);
    rd(2'b00, 1, d);  check("R1 cfg1 readback", d, 32'h0F0B_0903);
    check("R12 entry5 byte on flat", cfg_flat[8*5 +: 8], 8'h09);
    check("R12 entry7 byte on flat", cfg_flat[8*7 +: 8], 8'h0F);
    @(negedge clk);
    check("R11 pulse lasts one cycle", cfg_changed, 0);
    wr(2'b00, 1, 32'h0F0B_0903);
    check("R11 no pulse on same value", cfg_changed, 0);
    wr(2'b01, 3, 32'h1234_5678);
    rd(2'b01, 3, d);  check("R6 unlocked addr write", d, 32'h1234_5678);
    check("R12 addr3 on flat", addr_flat[XL*3 +: XL], 32'h1234_5678);
  endtask

  task automatic t_base_lock();
    logic [XL-1:0] d;
    enh_en = 1'b0;
    wr(2'b00, 0, 32'h0000_8001);
    wr(2'b00, 0, 32'h0000_0707);
    rd(2'b00, 0, d);  check("R2 locked byte kept, neighbour written", d, 32'h0000_8007);
    wr(2'b00, 0, 32'h8800_0007);
    rd(2'b00, 0, d);  check("R2 lock top-of-range entry3", d, 32'h8800_8007);
    wr(2'b01, 1, 32'h0000_AAAA);
    rd(2'b01, 1, d);  check("R6 own lock drops addr", d, 0);
    wr(2'b01, 2, 32'h0000_BBBB);
    rd(2'b01, 2, d);  check("R6 next locked TOR drops addr", d, 0);
    wr(2'b01, 0, 32'h0000_CCCC);
    rd(2'b01, 0, d);  check("R6 next locked non-TOR accepts", d, 32'h0000_CCCC);
    wr(2'b01, 4, 32'h0000_DDDD);
    rd(2'b01, 4, d);  check("R6 next unlocked TOR accepts", d, 32'h0000_DDDD);
    wr(2'b10, 0, 32'h4);
    rd(2'b10, 0, d);  check("R8 bypass refused with locks", d, 0);
  endtask

  task automatic t_bypass();
    logic [XL-1:0] d;
    do_reset();
    t_reset();
    enh_en = 1'b1;
    wr(2'b10, 0, 32'h4);
    check("R11 no pulse on security write", cfg_changed, 0);
    rd(2'b10, 0, d);  check("R8 bypass set with no locks", d, 32'h4);
    wr(2'b00, 0, 32'h0000_0080);
    wr(2'b00, 0, 32'h0000_0003);
    rd(2'b00, 0, d);  check("R3 bypass overrides lock", d, 32'h3);
    wr(2'b10, 0, 32'h0);
    check("R7 bypass clears", sec_bypass, 0);
    wr(2'b00, 0, 32'h0000_0080);
    rd(2'b00, 0, d);  check("R4 unlocked entry accepts", d, 32'h80);
    wr(2'b00, 0, 32'h0000_0001);
    rd(2'b00, 0, d);  check("R4 locked entry drops", d, 32'h80);
    wr(2'b10, 0, 32'h4);
    check("R8 bypass refused while locked", sec_bypass, 0);
  endtask

  task automatic t_lockdown();
    logic [XL-1:0] d;
    wr(2'b10, 0, 32'h1);
    wr(2'b10, 0, 32'h0);
    check("R7 lockdown sticky", sec_lockdown, 1);
    wr(2'b10, 0, 32'h2);
    wr(2'b10, 0, 32'h0);
    rd(2'b10, 0, d);  check("R7 whitelist sticky", d, 32'h3);
    wr(2'b00, 0, 32'h0000_0086);
    rd(2'b00, 0, d);  check("R5 lock+exec dropped", d, 32'h80);
    wr(2'b00, 0, 32'h0000_0083);
    rd(2'b00, 0, d);  check("R5 lock without exec accepted", d, 32'h83);
    wr(2'b00, 0, 32'h0000_0006);
    rd(2'b00, 0, d);  check("R5 unlocked write+exec dropped", d, 32'h83);
    wr(2'b00, 0, 32'h0000_0007);
    rd(2'b00, 0, d);  check("R5 unlocked RWX accepted", d, 32'h07);
  endtask

  task automatic t_range();
    logic [XL-1:0] d;
    logic [8*N-1:0]  cfg_snap;
    logic [XL*N-1:0] addr_snap;
    cfg_snap  = cfg_flat;
    addr_snap = addr_flat;
    wr(2'b00, 4, 32'hFFFF_FFFF);
    check("R11 no pulse out of range", cfg_changed, 0);
    wr(2'b01, 16, 32'hFFFF_FFFF);
    wr(2'b11, 0, 32'hFFFF_FFFF);
    check("R9 cfg unchanged", 64'(cfg_flat == cfg_snap), 1);
    check("R9 addr unchanged", 64'(addr_flat == addr_snap), 1);
    rd(2'b00, 4, d);  check("R9 cfg index beyond reads zero", d, 0);
    rd(2'b01, 16, d); check("R9 addr index beyond reads zero", d, 0);
    rd(2'b11, 0, d);  check("R9 unused kind reads zero", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_packing();
    t_base_lock();
    t_bypass();
    t_lockdown();
    t_range();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule